// File: doc/BRIEF.md
# Spanning-Tree Carry-Lookahead Adder

This block is a wide, purely combinational binary adder. Its default width of 91 bits suits a fine-resolution timestamp accumulator. It adds two operands and a carry-in, and returns the sum and a carry-out. It has no registers. Any timing around it belongs to the surrounding logic.

The word is cut into fixed-width slices, four bits each by default. When the width is not a multiple of the slice width, the top slice is narrower: 91 bits gives 22 full slices and one 3-bit slice.

For each slice, one part computes the slice's generate and propagate. It uses per-bit terms, with generate as the AND of the operand bits and propagate as their OR, and folds them from the slice's lowest bit upward. A log-depth prefix network then combines these slice-level pairs. Its only results are the carry entering each slice boundary and the final carry-out. No carry is pushed back down to individual bit positions.

The second part is a set of dual-result slices. Each slice ripples two conditional carry chains in parallel, one starting from 0 and one from 1. The boundary carry from the tree then picks one of the two precomputed sums.

Top module: `sta_adder`

## Requirements
- R1: `sum_o` equals the low WIDTH bits of `a_i + b_i + cin_i` for every input combination.
- R2: `cout_o` equals bit WIDTH of the (WIDTH+1)-bit result of `a_i + b_i + cin_i`.
- R3: With both operands all ones and `cin_i`=1, `sum_o` is all ones and `cout_o` is 1. With `a_i` all ones, `b_i`=0 and `cin_i`=1, `sum_o` is 0 and `cout_o` is 1.
- R4: When `b_i` is the bitwise inverse of `a_i`, every bit propagates. `cin_i`=0 then gives an all-ones `sum_o` with `cout_o`=0, and `cin_i`=1 gives `sum_o`=0 with `cout_o`=1.
- R5: With `b_i`=0 and `cin_i`=0, `sum_o` equals `a_i` and `cout_o` is 0. In particular, zero plus zero gives zero.
- R6: The carry entering slice k (k ≥ 1, with slice k starting at bit k·SEC_W) equals bit k·SEC_W of the sum of the low k·SEC_W bits of both operands plus `cin_i`. Slice 0 receives `cin_i` itself.
- R7: A carry leaving the narrower top slice (bits (NSEC−1)·SEC_W to WIDTH−1) reaches `cout_o`, and the carry entering that slice reaches bit (NSEC−1)·SEC_W of the sum.
- R8: The adder is commutative: swapping `a_i` and `b_i` leaves `sum_o` and `cout_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Low WIDTH bits of the sum |
| cout_o | output | 1 | Carry out of bit WIDTH−1 |

## Verification
A wrong boundary carry from the prefix network makes the affected slice select the wrong precomputed sum. The error then shows in that slice's bits of `sum_o` as soon as the inputs settle.

A fault inside one conditional ripple chain stays hidden until the tree selects that chain. Operands that force a carry across each slice boundary, with and without the carry, are therefore needed to expose both halves of every slice.

A fault in the whole-word group terms appears only in `cout_o`, and only when the carry is produced high in the word or travels the full length. For that reason the all-ones and full-propagate cases are checked directly.

// File: rtl/sta_pkg.sv
package sta_pkg;

    // Generate/propagate pair for a bit group.
    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a higher group with the group directly below it.
    function automatic gp_t gp_merge(input gp_t hi, input gp_t lo);
        gp_t r;
        r.g = (lo.g & hi.p) | hi.g;
        r.p = lo.p & hi.p;
        return r;
    endfunction

    // Carry leaving a group, given the carry entering the word.
    function automatic logic gp_carry(input gp_t grp, input logic cin);
        return grp.g | (grp.p & cin);
    endfunction

    function automatic int unsigned num_sections(input int unsigned width,
                                                 input int unsigned sec_w);
        return (width + sec_w - 1) / sec_w;
    endfunction

endpackage

// File: rtl/sta_group_gp.sv
module sta_group_gp
    import sta_pkg::*;
#(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output gp_t          grp_o
);
    logic [W-1:0] gen;
    logic [W-1:0] prop;

    assign gen  = a_i & b_i;
    assign prop = a_i | b_i;

    // Fold bit terms from the low end upward.
    always_comb begin
        grp_o.g = gen[0];
        grp_o.p = prop[0];
        for (int i = 1; i < W; i++) begin
            grp_o.g = (grp_o.g & prop[i]) | gen[i];
            grp_o.p = grp_o.p & prop[i];
        end
    end
endmodule

// File: rtl/sta_prefix_tree.sv
module sta_prefix_tree
    import sta_pkg::*;
#(
    parameter int unsigned N = 23
) (
    input  gp_t [N-1:0] sec_gp_i,
    input  logic        cin_i,
    output logic [N-1:0] sec_cin_o,
    output logic        cout_o
);
    localparam int unsigned LEVELS = (N > 1) ? $clog2(N) : 0;

    gp_t [N-1:0] lvl [0:LEVELS];

    assign lvl[0] = sec_gp_i;

    // Parallel prefix: each level doubles the span each node covers.
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned DIST = 1 << l;
        for (genvar i = 0; i < N; i++) begin : g_node
            if (i >= DIST) begin : g_merge
                assign lvl[l+1][i] = gp_merge(lvl[l][i], lvl[l][i-DIST]);
            end else begin : g_pass
                assign lvl[l+1][i] = lvl[l][i];
            end
        end
    end

    // Boundary carries only; nothing flows back to bit level.
    assign sec_cin_o[0] = cin_i;
    for (genvar k = 1; k < N; k++) begin : g_cin
        assign sec_cin_o[k] = gp_carry(lvl[LEVELS][k-1], cin_i);
    end

    assign cout_o = gp_carry(lvl[LEVELS][N-1], cin_i);
endmodule

// File: rtl/sta_csel_section.sv
module sta_csel_section #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sel_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] sum_c0;
    logic [W-1:0] sum_c1;

    // Two conditional ripple chains, each feeding its own next bit.
    always_comb begin
        logic c0;
        logic c1;
        c0 = 1'b0;
        c1 = 1'b1;
        for (int i = 0; i < W; i++) begin
            sum_c0[i] = a_i[i] ^ b_i[i] ^ c0;
            sum_c1[i] = a_i[i] ^ b_i[i] ^ c1;
            c0 = (a_i[i] & b_i[i]) | ((a_i[i] | b_i[i]) & c0);
            c1 = (a_i[i] & b_i[i]) | ((a_i[i] | b_i[i]) & c1);
        end
    end

    assign sum_o = sel_i ? sum_c1 : sum_c0;
endmodule

// File: rtl/sta_adder.sv
module sta_adder
    import sta_pkg::*;
#(
    parameter int unsigned WIDTH = 91,
    parameter int unsigned SEC_W = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);
    localparam int unsigned NSEC   = num_sections(WIDTH, SEC_W);
    localparam int unsigned LAST_W = WIDTH - (NSEC - 1) * SEC_W;

    gp_t  [NSEC-1:0] sec_gp;
    logic [NSEC-1:0] sec_cin;

    for (genvar k = 0; k < NSEC; k++) begin : g_sec
        localparam int unsigned LO = k * SEC_W;
        localparam int unsigned SW = (k == NSEC - 1) ? LAST_W : SEC_W;

        sta_group_gp #(.W(SW)) u_gp (
            .a_i   (a_i[LO +: SW]),
            .b_i   (b_i[LO +: SW]),
            .grp_o (sec_gp[k])
        );

        sta_csel_section #(.W(SW)) u_sel (
            .a_i   (a_i[LO +: SW]),
            .b_i   (b_i[LO +: SW]),
            .sel_i (sec_cin[k]),
            .sum_o (sum_o[LO +: SW])
        );
    end

    sta_prefix_tree #(.N(NSEC)) u_tree (
        .sec_gp_i  (sec_gp),
        .cin_i     (cin_i),
        .sec_cin_o (sec_cin),
        .cout_o    (cout_o)
    );
endmodule

// File: rtl/sta_adder_chk.sv
module sta_adder_chk #(
    parameter int unsigned WIDTH = 91,
    parameter int unsigned SEC_W = 4,
    parameter int unsigned NSEC  = 23
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic             cin_i,
    input logic [WIDTH-1:0] sum_o,
    input logic             cout_o,
    input logic [NSEC-1:0]  sec_cin
);
    logic [WIDTH:0] full;
    assign full = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};

    always_comb begin
        a_r1_sum_matches: assert (sum_o == full[WIDTH-1:0]);
        a_r2_carry_out:   assert (cout_o == full[WIDTH]);
        if (&a_i && &b_i && cin_i)
            a_r3_all_ones: assert (&sum_o && cout_o);
        if ((a_i ^ b_i) == {WIDTH{1'b1}})
            a_r4_propagate: assert ((sum_o == {WIDTH{~cin_i}}) && (cout_o == cin_i));
        if (b_i == '0 && !cin_i)
            a_r5_identity: assert ((sum_o == a_i) && !cout_o);
        a_r6_sec0_carry: assert (sec_cin[0] == cin_i);
    end

    // R6: every slice boundary carry matches a reference partial addition
    for (genvar k = 1; k < NSEC; k++) begin : g_bnd
        localparam int unsigned LO = k * SEC_W;
        logic [WIDTH:0] mask;
        logic [WIDTH:0] part;
        assign mask = ({{WIDTH{1'b0}}, 1'b1} << LO) - 1'b1;
        assign part = ({1'b0, a_i} & mask) + ({1'b0, b_i} & mask)
                    + {{WIDTH{1'b0}}, cin_i};
        always_comb begin
            a_r6_boundary_carry: assert (sec_cin[k] == part[LO]);
        end
    end
endmodule

bind sta_adder sta_adder_chk #(
    .WIDTH (WIDTH),
    .SEC_W (SEC_W),
    .NSEC  (NSEC)
) u_chk (
    .a_i     (a_i),
    .b_i     (b_i),
    .cin_i   (cin_i),
    .sum_o   (sum_o),
    .cout_o  (cout_o),
    .sec_cin (sec_cin)
);

// File: tb/sta_adder_tb_top.sv
module sta_adder_tb_top;
    localparam int unsigned W    = 91;
    localparam int unsigned S    = 4;
    localparam int unsigned NSEC = (W + S - 1) / S;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sta_adder #(.WIDTH(W), .SEC_W(S)) dut_i (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout)
    );

    // Drive on the falling edge, sample 2 ns after the next rising edge.
    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic c, input string req);
        logic [W:0] exp;
        @(negedge clk);
        a = x; b = y; cin = c;
        @(posedge clk);
        #2;
        exp = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        checks++;
        if ({cout, sum} !== exp) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%0d got=%h expected=%h",
                     req, x, y, c, {cout, sum}, exp);
        end
    endtask

    task automatic t_reset_state;
        @(posedge clk);
        #2;
        checks++;
        if ({cout, sum} !== '0) begin
            fails++;
            $display("FAIL R5 idle: got=%h expected=0", {cout, sum});
        end
    endtask

    task automatic t_zero;
        apply('0, '0, 1'b0, "R5 zero+zero");
        apply({W{1'b1}} >> 7, '0, 1'b0, "R5 identity");
        apply('0, '0, 1'b1, "R1 zero with carry-in");
    endtask

    task automatic t_all_ones;
        apply({W{1'b1}}, '0, 1'b1, "R3 ones plus carry-in");
        apply({W{1'b1}}, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R3 ones plus one");
        apply({W{1'b1}}, {W{1'b1}}, 1'b1, "R3 ones plus ones");
    endtask

    task automatic t_propagate;
        logic [W-1:0] pat;
        pat = {(W+1)/2{2'b10}};
        apply(pat, ~pat, 1'b0, "R4 propagate cin0");
        apply(pat, ~pat, 1'b1, "R4 propagate cin1");
        apply('0, {W{1'b1}}, 1'b1, "R4 propagate zero/ones");
    endtask

    task automatic t_boundaries;
        for (int k = 1; k < NSEC; k++) begin
            logic [W-1:0] low;
            low = ({{(W-1){1'b0}}, 1'b1} << (k * S)) - 1'b1;
            apply(low, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R6 generate into boundary");
            apply(low, '0, 1'b1, "R6 carry-in into boundary");
            apply(low, '0, 1'b0, "R6 no carry at boundary");
        end
    endtask

    task automatic t_last_section;
        logic [W-1:0] top;
        top = {W{1'b1}} << ((NSEC - 1) * S);
        apply(top, top, 1'b0, "R7 top slice carry-out");
        apply(~top, {{(W-1){1'b0}}, 1'b1}, 1'b0, "R7 carry into top slice");
        apply(top | (~top), '0, 1'b1, "R7 full ripple through top slice");
    endtask

    task automatic t_random;
        for (int n = 0; n < 300; n++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            logic         c;
            for (int j = 0; j < W; j += 32) begin
                x = (x << 32) | W'($urandom);
                y = (y << 32) | W'($urandom);
            end
            c = 1'($urandom);
            apply(x, y, c, "R1 R2 random");
            apply(y, x, c, "R8 swapped operands");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_zero();
        t_all_ones();
        t_propagate();
        t_boundaries();
        t_last_section();
        t_random();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule